// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that lets a host read and write registers inside Ethernet PHYs over the two-wire MDC/MDIO interface. The host sees two 32-bit registers on a simple write/read port: a command register and a data register. It loads the data register first. It then writes the command register with the start bit set, and that write launches one management transaction.

The block generates MDC from the system clock, using a divider picked by a clock-range code. It drives MDIO through separate output, output-enable and input signals. Two frame formats are supported. The short format sends one frame that carries a 5-bit register number. The extended format sends an address frame that carries a 16-bit register address, followed by a write or read frame, and both frames run within a single busy period. Read data is returned in the low half of the data register when busy clears.

A command write with the start bit clear still produces one MDC cycle, with MDIO released. Some PHYs need to see an MDC edge before they leave reset, and this write provides it.

Top module: `mdio_master`

## Requirements
- R1: Command register bit 0 reads 1 from the first clock after a launching write until the last frame of the transaction has finished, then reads 0.
- R2: Command register layout: bit 0 start/busy; bit 1 selects the extended (address + operation) format; bits 3:2 operation, 01 write and 11 read (bit 3 set means read); bits 11:8 clock-range code; bits 20:16 register number (short format) or device address (extended format); bits 25:21 PHY address. Other bits read back as 0. Data register: bits 15:0 write/read data; bits 31:16 the register address in the extended format.
- R3: A short-format frame is, MSB first: 32 ones, start 01, opcode (01 write / 10 read), PHY address, register number, turnaround 10, 16 data bits. MDIO output-enable is high for all 64 bits of a write.
- R4: During a read, MDIO output-enable drops for the two turnaround bits and the 16 data bits. The 16 bits sampled on MDC rising edges, MSB first, land in data register bits 15:0, and bits 31:16 are kept.
- R5: An extended access sends an address frame (start 00, opcode 00, PHY, device, turnaround 10, data bits 31:16), then a frame with start 00, opcode 01 (write) or 11 (read), the same PHY and device, and data bits 15:0 or the read slot. Both frames fall under one busy period (128 MDC rises).
- R6: Writes to either register while busy is set are ignored. They change neither the register contents nor the transaction in flight, and they start no further frame.
- R7: A command write with bit 0 clear gives exactly one MDC rising edge, with MDIO output-enable low.
- R8: The MDC period in system clocks is 16, 26, 42, 62, 102 or 124 for clock-range codes 0 to 5, and 124 for any larger code. MDIO output and output-enable change only while MDC falls, never while MDC is high.
- R9: After reset, both registers read 0 and MDC and MDIO output-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select: 0 command, 1 data |
| regWr | input | 1 | Write strobe for the selected register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the pin |

## Verification
The bench snoops MDIO on every MDC rise, keeping the last 128 bits and output enables along with the clock count of each rise. Most internal faults then show up as a wrong frame word or a wrong rise count once busy drops. A stale sequencer state leaves busy stuck or runs an extra frame. A wrong bit counter shifts or truncates the frame. A wrong capture position corrupts the read value in the data register. A bad divider entry changes the measured MDC period within two MDC cycles.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_W = 32;

  // strobes from the sequencer to the serial engine
  typedef struct packed {
    logic                start;
    logic                isRead;
    logic                isDummy;
    logic [3:0]          clkSel;
    logic [FRAME_W-1:0]  frame;
  } mdioStrobe_t;

  // half of the MDC period, in system clocks
  function automatic logic [6:0] halfPeriod(input logic [3:0] sel);
    case (sel)
      4'd0:    return 7'd8;
      4'd1:    return 7'd13;
      4'd2:    return 7'd21;
      4'd3:    return 7'd31;
      4'd4:    return 7'd51;
      default: return 7'd62;
    endcase
  endfunction

endpackage

// File: rtl/mdio_shift.sv
module mdio_shift
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       stb,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              done,
  output logic [DATA_W-1:0] capData
);
  localparam int TOTAL = PRE_LEN + FRAME_W;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + 16);

  logic               active, mdcQ, rdQ, dummyQ, doneQ;
  logic [IDX_W-1:0]   idx;
  logic [6:0]         halfCnt, halfReload;
  logic [FRAME_W-1:0] frameSh;
  logic [DATA_W-1:0]  capQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0; mdcQ <= 1'b0; rdQ <= 1'b0; dummyQ <= 1'b0; doneQ <= 1'b0;
      idx <= '0; halfCnt <= '0; halfReload <= '0; frameSh <= '0; capQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!active) begin
        if (stb.start) begin
          active     <= 1'b1;
          mdcQ       <= 1'b0;
          idx        <= '0;
          halfReload <= halfPeriod(stb.clkSel) - 7'd1;
          halfCnt    <= halfPeriod(stb.clkSel) - 7'd1;
          frameSh    <= stb.frame;
          rdQ        <= stb.isRead;
          dummyQ     <= stb.isDummy;
        end
      end else if (halfCnt != '0) begin
        halfCnt <= halfCnt - 7'd1;
      end else begin
        halfCnt <= halfReload;
        if (!mdcQ) begin
          mdcQ <= 1'b1;                       // rising edge: sample
          if (rdQ && idx >= DAT_IDX) capQ <= {capQ[DATA_W-2:0], mdioIn};
        end else begin
          mdcQ <= 1'b0;                       // falling edge: advance
          if (idx >= PRE_IDX) frameSh <= frameSh << 1;
          if (dummyQ || idx == LAST_IDX) begin
            active <= 1'b0;
            doneQ  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = active && ((idx < PRE_IDX) || frameSh[FRAME_W-1]);
  assign mdioOe  = active && !dummyQ && !(rdQ && idx >= TA_IDX);
  assign done    = doneQ;
  assign capData = capQ;

  // R8: pin outputs may move only on the edge where MDC falls
  p_out_stable_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    mdcQ |-> ($stable(mdioOut) && $stable(mdioOe)));
  // R9: MDC rests low between transactions
  p_mdc_idle_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !mdcQ);
  // R6: the sequencer never launches into a running engine
  p_start_when_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |-> !active);

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              dpDone,
  input  logic [DATA_W-1:0] capData,
  output mdioStrobe_t       stb
);
  localparam logic [31:0] CMD_MASK = 32'h03FF_0F0E;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_XFER, S_DUMMY} seqState_t;

  seqState_t   state;
  logic [31:0] cmdQ, dataQ;
  mdioStrobe_t stbQ;
  logic        busy;

  assign busy = (state != S_IDLE);

  function automatic logic [FRAME_W-1:0] mkFrame(
    input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
    input logic [4:0] fld, input logic [15:0] word);
    return {st, op, phy, fld, 2'b10, word};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; cmdQ <= '0; dataQ <= '0; stbQ <= '0;
    end else begin
      stbQ.start <= 1'b0;
      case (state)
        S_IDLE: if (regWr) begin
          if (regSel) begin
            dataQ <= regWdata;
          end else begin
            cmdQ         <= regWdata & CMD_MASK;
            stbQ.start   <= 1'b1;
            stbQ.clkSel  <= regWdata[11:8];
            stbQ.isDummy <= !regWdata[0];
            stbQ.isRead  <= regWdata[0] && !regWdata[1] && regWdata[3];
            if (!regWdata[0]) begin
              stbQ.frame <= '0;
              state      <= S_DUMMY;
            end else if (regWdata[1]) begin
              stbQ.frame <= mkFrame(2'b00, 2'b00, regWdata[25:21], regWdata[20:16], dataQ[31:16]);
              state      <= S_ADDR;
            end else begin
              stbQ.frame <= mkFrame(2'b01, regWdata[3] ? 2'b10 : 2'b01, regWdata[25:21],
                                    regWdata[20:16], dataQ[15:0]);
              state      <= S_XFER;
            end
          end
        end
        S_ADDR: if (dpDone) begin
          stbQ.start  <= 1'b1;
          stbQ.isRead <= cmdQ[3];
          stbQ.frame  <= mkFrame(2'b00, cmdQ[3] ? 2'b11 : 2'b01, cmdQ[25:21], cmdQ[20:16],
                                 dataQ[15:0]);
          state       <= S_XFER;
        end
        S_XFER: if (dpDone) begin
          if (cmdQ[3]) dataQ[DATA_W-1:0] <= capData;
          state <= S_IDLE;
        end
        default: if (dpDone) state <= S_IDLE;
      endcase
    end
  end

  assign stb      = stbQ;
  assign regRdata = regSel ? dataQ : {cmdQ[31:1], busy};

  // R6: command fields frozen while a transaction runs
  p_cmd_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cmdQ));
  // R6: data register only changes by read capture while busy
  p_data_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(state == S_XFER && dpDone)) |=> $stable(dataQ));
  // R1: completion of the final frame clears busy
  p_done_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    (dpDone && state != S_ADDR) |=> !busy);
  // R5: launch strobes are single-cycle pulses
  p_single_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    stbQ.start |=> !stbQ.start);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t       stb;
  logic              dpDone;
  logic [DATA_W-1:0] capData;

  mdio_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .dpDone(dpDone),
    .capData(capData), .stb(stb));

  mdio_shift #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rstN(rstN), .stb(stb), .mdioIn(mdioIn), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .done(dpDone), .capData(capData));

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, regWr = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn, phyBit;

  int checks = 0, errors = 0;
  int cycCnt = 0, riseCnt = 0, lastRise = 0, prevRise = 0;
  int base = 0;
  logic [15:0]  rdVal = '0;
  logic [127:0] busBits = '0, busOe = '0;

  always #4 clk = ~clk;   // 125 MHz

  mdio_master u0 (.clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn));

  always @(posedge clk) cycCnt <= cycCnt + 1;

  always @(posedge mdc) begin
    busBits  <= {busBits[126:0], mdioOut};
    busOe    <= {busOe[126:0], mdioOe};
    riseCnt  <= riseCnt + 1;
    prevRise <= lastRise;
    lastRise <= cycCnt;
  end

  // PHY model: drives read data in data slots, pull-up elsewhere
  always_comb begin
    int pos;
    pos = riseCnt - base;
    phyBit = 1'b1;
    if (pos >= 48 && pos < 64) phyBit = rdVal[15 - (pos - 48)];
  end
  assign mdioIn = mdioOe ? mdioOut : phyBit;

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic sel, output logic [31:0] d);
    regSel = sel; #1; d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      regRead(1'b0, v);
      if (!v[0]) return;
    end
  endtask

  function automatic logic [31:0] cmdWord(input logic c45, input logic rd,
    input logic [3:0] sel, input logic [4:0] fld, input logic [4:0] phy);
    return {6'b0, phy, fld, 4'b0, sel, 4'b0, rd, 1'b1, c45, 1'b1};
  endfunction

  task automatic testReset();
    logic [31:0] v;
    regRead(1'b0, v); check("R9 cmd after reset", v, 0);
    regRead(1'b1, v); check("R9 data after reset", v, 0);
    check("R9 mdc/oe after reset", {mdc, mdioOe}, 0);
  endtask

  task automatic testC22Write();
    logic [31:0] v; int start;
    regWrite(1'b1, 32'h0000_A5C3);
    start = riseCnt;
    regWrite(1'b0, cmdWord(0, 0, 4'd0, 5'h0A, 5'h11));
    regRead(1'b0, v); check("R1 busy after launch", v[0], 1);
    waitIdle();
    check("R1 busy cleared", u0.regRdata[0], 0);
    check("R3 rise count", riseCnt - start, 64);
    check("R3 write frame", busBits[63:0],
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h0A, 2'b10, 16'hA5C3});
    check("R3 write oe", busOe[63:0], {64{1'b1}});
    check("R8 period code 0", lastRise - prevRise, 16);
  endtask

  task automatic testC22Read();
    logic [31:0] v;
    regWrite(1'b1, 32'hBEEF_0000);
    rdVal = 16'h3C96; base = riseCnt;
    regWrite(1'b0, cmdWord(0, 1, 4'd1, 5'h1F, 5'h00));
    waitIdle();
    check("R3 read header", busBits[63:18],
          {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h00, 5'h1F});
    check("R4 read oe", busOe[63:0], {{46{1'b1}}, 18'b0});
    regRead(1'b1, v); check("R4 read data", v, 32'hBEEF_3C96);
    check("R8 period code 1", lastRise - prevRise, 26);
  endtask

  task automatic testC45Write();
    int start;
    regWrite(1'b1, 32'h1234_CAFE);
    start = riseCnt;
    regWrite(1'b0, cmdWord(1, 0, 4'd0, 5'h07, 5'h03));
    waitIdle();
    check("R5 rise count", riseCnt - start, 128);
    check("R5 address frame", busBits[127:64],
          {32'hFFFF_FFFF, 2'b00, 2'b00, 5'h03, 5'h07, 2'b10, 16'h1234});
    check("R5 write frame", busBits[63:0],
          {32'hFFFF_FFFF, 2'b00, 2'b01, 5'h03, 5'h07, 2'b10, 16'hCAFE});
  endtask

  task automatic testC45Read();
    logic [31:0] v;
    regWrite(1'b1, 32'h0042_0000);
    rdVal = 16'h8001; base = riseCnt + 64;
    regWrite(1'b0, cmdWord(1, 1, 4'd0, 5'h1E, 5'h15));
    waitIdle();
    check("R5 read address frame", busBits[127:64],
          {32'hFFFF_FFFF, 2'b00, 2'b00, 5'h15, 5'h1E, 2'b10, 16'h0042});
    check("R5 read op header", busBits[63:18],
          {32'hFFFF_FFFF, 2'b00, 2'b11, 5'h15, 5'h1E});
    check("R4 c45 read oe", busOe[63:0], {{46{1'b1}}, 18'b0});
    regRead(1'b1, v); check("R4 c45 read data", v, 32'h0042_8001);
  endtask

  task automatic testIgnore();
    logic [31:0] v, cmd; int start;
    regWrite(1'b1, 32'h0000_1111);
    cmd = cmdWord(0, 0, 4'd0, 5'h02, 5'h01);
    start = riseCnt;
    regWrite(1'b0, cmd);
    repeat (40) @(negedge clk);
    regWrite(1'b1, 32'hFFFF_FFFF);
    regWrite(1'b0, 32'hFFFF_FFFF);
    waitIdle();
    regRead(1'b1, v); check("R6 data unchanged", v, 32'h0000_1111);
    regRead(1'b0, v); check("R6 cmd unchanged", v, cmd & 32'h03FF_FFFE);
    repeat (40) @(negedge clk);
    check("R6 no extra frame", riseCnt - start, 64);
    check("R6 frame intact", busBits[15:0], 16'h1111);
  endtask

  task automatic testDummy();
    logic [31:0] v; int start;
    start = riseCnt;
    regWrite(1'b0, 32'h0);
    waitIdle();
    repeat (20) @(negedge clk);
    check("R7 one mdc edge", riseCnt - start, 1);
    check("R7 mdio released", busOe[0], 0);
    regRead(1'b0, v); check("R2 cmd readback zero", v, 0);
  endtask

  task automatic testSlowDiv();
    regWrite(1'b0, cmdWord(0, 0, 4'd7, 5'h00, 5'h00));
    waitIdle();
    check("R8 period out-of-range code", lastRise - prevRise, 124);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testC22Write();
    testC22Read();
    testC45Write();
    testC45Read();
    testIgnore();
    testDummy();
    testSlowDiv();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule